// File: doc/BRIEF.md
# SIMD Modified-Immediate Execution Unit

This unit runs the one-register SIMD instructions that carry an encoded immediate. Each request supplies an 8-bit immediate, a 4-bit constant-shape selector (`cmode_i`), an invert/variant bit (`op_i`), a destination register index, a quad flag and the destination's current contents. From the selector and the variant bit, the unit builds a 64-bit constant. It then applies one of three operations to the destination: OR, AND, or a plain move.

The new destination value is returned one cycle later with a write enable. If the request is undefined, it is returned with an undefined flag and no write. A configuration input states whether the register file has only 16 double registers. The register file itself lives outside this unit.

The constant shapes are:
- a single byte placed at any of four byte positions;
- a byte repeated in each halfword;
- a byte above a run of ones;
- a byte replicated in every byte;
- a per-bit byte mask;
- a compact floating-point pattern.

Top module: `simd_imm_unit`

## Requirements
- R1: For `cmode_i` 0/1, 2/3, 4/5 and 6/7, the 32-bit word holds the immediate at bit offset 0, 8, 16 and 24, with all other bits zero.
- R2: For `cmode_i` 8/9, the word holds the immediate in bits 7:0 and 23:16. For `cmode_i` 10/11, it holds the immediate in bits 15:8 and 31:24.
- R3: For `cmode_i` 12, the word is the immediate in bits 15:8 with bits 7:0 all ones. For `cmode_i` 13, it is the immediate in bits 23:16 with bits 15:0 all ones.
- R4: For `cmode_i` 14 with `op_i`=0, the immediate fills all four bytes. For `cmode_i` 14 with `op_i`=1, byte n of the 64-bit constant is 0xFF when immediate bit n is 1 and 0x00 otherwise, and no inversion is applied.
- R5: For `cmode_i` 15, the word's bits are set as follows. Bit 31 is immediate bit 7, and bits 24:19 are immediate bits 5:0. If immediate bit 6 is 1, bits 29:25 are ones and bit 30 is zero. Otherwise, bit 30 is one and bits 29:25 are zero. All other bits are zero.
- R6: With `op_i`=1 and `cmode_i` other than 14, the word is bitwise inverted. The final word is copied into both 32-bit halves of the 64-bit constant.
- R7: For an odd `cmode_i` below 12, the result is destination OR constant when `op_i`=0, and destination AND constant when `op_i`=1. All other defined encodings write the constant itself.
- R8: `cmode_i`=15 with `op_i`=1 gives `res_undef_o`=1 and `res_we_o`=0.
- R9: A request is undefined in two cases: `quad_i`=1 with `dreg_i[0]`=1, or `few_dregs_i`=1 with `dreg_i[4]`=1.
- R10: With `quad_i`=1, the operation is applied to both 64-bit halves of `src_data_i` using the same constant. With `quad_i`=0, only bits 63:0 are computed and `res_data_o[127:64]` is zero.
- R11: A zero immediate gives no special case in any shifted mode. It yields the constant that the rules above produce.
- R12: `req_ready_o` is always 1. Results appear on the clock edge after acceptance. `res_valid_o` is low in a cycle that follows no request, and asynchronous reset clears `res_valid_o`, `res_we_o` and `res_undef_o`. When a result is undefined, `res_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| few_dregs_i | input | 1 | Register file has only 16 double registers |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (always high) |
| imm_i | input | 8 | Encoded immediate |
| cmode_i | input | 4 | Constant shape selector |
| op_i | input | 1 | Invert / variant bit |
| dreg_i | input | 5 | Destination double-register index |
| quad_i | input | 1 | 128-bit operation |
| src_data_i | input | 128 | Current destination contents |
| res_valid_o | output | 1 | Result valid |
| res_we_o | output | 1 | Write destination |
| res_undef_o | output | 1 | Instruction undefined |
| res_data_o | output | 128 | New destination value |

## Verification
Every output comes from a single register stage. The data, write enable, undefined flag and valid for a request are therefore due exactly one clock after the edge that accepts it, and an idle input is reflected after that same single cycle. The bench applies each request on a falling edge and lets one rising edge pass. It samples on the next falling edge, before the next request can move the outputs. Back-to-back requests are checked one per cycle to show that no result is delayed or overwritten.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;
  localparam int IMM_W   = 8;
  localparam int CMODE_W = 4;
  localparam int WORD_W  = 32;
  localparam int CONST_W = 2 * WORD_W;
  localparam int LANES   = 2;
  localparam int DATA_W  = LANES * CONST_W;
  localparam int DREG_W  = 5;

  typedef enum logic [1:0] {
    ALU_MOVE = 2'd0,
    ALU_OR   = 2'd1,
    ALU_AND  = 2'd2
  } alu_op_e;
endpackage

// File: rtl/simd_imm_expand.sv
module simd_imm_expand
  import simd_imm_pkg::*;
(
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [CMODE_W-1:0] cmode_i,
  input  logic               op_i,
  output logic [CONST_W-1:0] cst_o
);
  localparam int NBYTES = CONST_W / 8;

  logic [WORD_W-1:0]  word;
  logic [WORD_W-1:0]  word_fp;
  logic [WORD_W-1:0]  word_fin;
  logic [CONST_W-1:0] byte_mask;
  logic               do_inv;
  logic               mask_mode;

  // compact float: sign, exponent pattern from bit 6, fraction top bits
  assign word_fp = {imm_i[7], ~imm_i[6], {5{imm_i[6]}}, imm_i[5:0], 19'b0};

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign byte_mask[8*b +: 8] = {8{imm_i[b]}};
  end

  always_comb begin
    unique case (cmode_i[3:1])
      3'd0:    word = {24'b0, imm_i};
      3'd1:    word = {16'b0, imm_i, 8'b0};
      3'd2:    word = {8'b0, imm_i, 16'b0};
      3'd3:    word = {imm_i, 24'b0};
      3'd4:    word = {8'b0, imm_i, 8'b0, imm_i};
      3'd5:    word = {imm_i, 8'b0, imm_i, 8'b0};
      3'd6:    word = cmode_i[0] ? {8'b0, imm_i, 16'hffff} : {16'b0, imm_i, 8'hff};
      default: word = cmode_i[0] ? word_fp : {4{imm_i}};
    endcase
  end

  assign mask_mode = (cmode_i == 4'd14) && op_i;
  assign do_inv    = op_i && (cmode_i != 4'd14);
  assign word_fin  = do_inv ? ~word : word;
  assign cst_o     = mask_mode ? byte_mask : {2{word_fin}};
endmodule

// File: rtl/simd_imm_decode.sv
module simd_imm_decode
  import simd_imm_pkg::*;
(
  input  logic [CMODE_W-1:0] cmode_i,
  input  logic               op_i,
  input  logic [DREG_W-1:0]  dreg_i,
  input  logic               quad_i,
  input  logic               few_dregs_i,
  output alu_op_e            alu_op_o,
  output logic               undef_o
);
  logic bad_enc;
  logic bad_align;
  logic bad_bank;

  assign bad_enc   = (cmode_i == 4'd15) && op_i;
  assign bad_align = quad_i && dreg_i[0];
  assign bad_bank  = few_dregs_i && dreg_i[DREG_W-1];
  assign undef_o   = bad_enc | bad_align | bad_bank;

  always_comb begin
    if (cmode_i[0] && (cmode_i < 4'd12)) alu_op_o = op_i ? ALU_AND : ALU_OR;
    else                                  alu_op_o = ALU_MOVE;
  end
endmodule

// File: rtl/simd_imm_lane.sv
module simd_imm_lane
  import simd_imm_pkg::*;
#(
  parameter int LANE_W = CONST_W
) (
  input  alu_op_e           alu_op_i,
  input  logic [LANE_W-1:0] src_i,
  input  logic [LANE_W-1:0] cst_i,
  output logic [LANE_W-1:0] res_o
);
  always_comb begin
    unique case (alu_op_i)
      ALU_OR:  res_o = src_i | cst_i;
      ALU_AND: res_o = src_i & cst_i;
      default: res_o = cst_i;
    endcase
  end
endmodule

// File: rtl/simd_imm_unit.sv
module simd_imm_unit
  import simd_imm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               few_dregs_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [CMODE_W-1:0] cmode_i,
  input  logic               op_i,
  input  logic [DREG_W-1:0]  dreg_i,
  input  logic               quad_i,
  input  logic [DATA_W-1:0]  src_data_i,
  output logic               res_valid_o,
  output logic               res_we_o,
  output logic               res_undef_o,
  output logic [DATA_W-1:0]  res_data_o
);
  logic [CONST_W-1:0] cst;
  alu_op_e            alu_op;
  logic               undef;
  logic               accept;
  logic [DATA_W-1:0]  nxt_data;

  assign req_ready_o = 1'b1;
  assign accept      = req_valid_i & req_ready_o;

  simd_imm_expand u_expand (
    .imm_i   (imm_i),
    .cmode_i (cmode_i),
    .op_i    (op_i),
    .cst_o   (cst)
  );

  simd_imm_decode u_decode (
    .cmode_i     (cmode_i),
    .op_i        (op_i),
    .dreg_i      (dreg_i),
    .quad_i      (quad_i),
    .few_dregs_i (few_dregs_i),
    .alu_op_o    (alu_op),
    .undef_o     (undef)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CONST_W-1:0] lane_res;
    logic               lane_en;

    simd_imm_lane #(.LANE_W(CONST_W)) u_lane (
      .alu_op_i (alu_op),
      .src_i    (src_data_i[l*CONST_W +: CONST_W]),
      .cst_i    (cst),
      .res_o    (lane_res)
    );

    // lane 0 always active; upper lanes only for quad
    assign lane_en = (l == 0) || quad_i;
    assign nxt_data[l*CONST_W +: CONST_W] = (lane_en && !undef) ? lane_res : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_we_o    <= 1'b0;
      res_undef_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= accept;
      res_we_o    <= accept & ~undef;
      res_undef_o <= accept & undef;
      if (accept) res_data_o <= nxt_data;
    end
  end
endmodule

// File: rtl/simd_imm_unit_chk.sv
module simd_imm_unit_chk
  import simd_imm_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               few_dregs_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [IMM_W-1:0]   imm_i,
  input logic [CMODE_W-1:0] cmode_i,
  input logic               op_i,
  input logic [DREG_W-1:0]  dreg_i,
  input logic               quad_i,
  input logic [DATA_W-1:0]  src_data_i,
  input logic               res_valid_o,
  input logic               res_we_o,
  input logic               res_undef_o,
  input logic [DATA_W-1:0]  res_data_o
);
  logic defined_req;
  assign defined_req = !((cmode_i == 4'd15) && op_i) && !(quad_i && dreg_i[0])
                       && !(few_dregs_i && dreg_i[DREG_W-1]);

  a_r12_ready: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o);
  a_r12_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  a_r12_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  a_r8_undef_enc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmode_i == 4'd15 && op_i) |=> (res_undef_o && !res_we_o));
  a_r9_quad_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && quad_i && dreg_i[0]) |=> (res_undef_o && !res_we_o));
  a_r9_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && few_dregs_i && dreg_i[DREG_W-1]) |=> res_undef_o);
  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_we_o && res_undef_o));
  a_r12_we_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o || res_undef_o) |-> res_valid_o);
  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !quad_i) |=> (res_data_o[DATA_W-1:CONST_W] == '0));
  a_r10_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && quad_i && defined_req && (!cmode_i[0] || cmode_i >= 4'd12))
    |=> (res_data_o[DATA_W-1:CONST_W] == res_data_o[CONST_W-1:0]));
  a_r7_or_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && defined_req && cmode_i[0] && cmode_i < 4'd12 && !op_i)
    |=> ((res_data_o[CONST_W-1:0] & $past(src_data_i[CONST_W-1:0]))
         == $past(src_data_i[CONST_W-1:0])));
endmodule

bind simd_imm_unit simd_imm_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .few_dregs_i (few_dregs_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .imm_i       (imm_i),
  .cmode_i     (cmode_i),
  .op_i        (op_i),
  .dreg_i      (dreg_i),
  .quad_i      (quad_i),
  .src_data_i  (src_data_i),
  .res_valid_o (res_valid_o),
  .res_we_o    (res_we_o),
  .res_undef_o (res_undef_o),
  .res_data_o  (res_data_o)
);

// File: tb/simd_imm_unit_tb.sv
module simd_imm_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;
  localparam logic [127:0] SRC = 128'h0123456789ABCDEF_FEDCBA9876543210;

  // {tag[3:0], kind[1:0] (0 move,1 or,2 and), cmode[3:0], op, imm[7:0], const[63:0]}
  localparam logic [82:0] VEC [NV] = '{
    {4'd1,  2'd0, 4'd0,  1'b0, 8'hA5, 64'h000000A5_000000A5}, // R1
    {4'd1,  2'd0, 4'd2,  1'b0, 8'hA5, 64'h0000A500_0000A500}, // R1
    {4'd1,  2'd0, 4'd4,  1'b0, 8'hA5, 64'h00A50000_00A50000}, // R1
    {4'd1,  2'd0, 4'd6,  1'b0, 8'hA5, 64'hA5000000_A5000000}, // R1
    {4'd2,  2'd0, 4'd8,  1'b0, 8'hA5, 64'h00A500A5_00A500A5}, // R2
    {4'd2,  2'd0, 4'd10, 1'b0, 8'hA5, 64'hA500A500_A500A500}, // R2
    {4'd3,  2'd0, 4'd12, 1'b0, 8'hA5, 64'h0000A5FF_0000A5FF}, // R3
    {4'd3,  2'd0, 4'd13, 1'b0, 8'hA5, 64'h00A5FFFF_00A5FFFF}, // R3
    {4'd4,  2'd0, 4'd14, 1'b0, 8'hA5, 64'hA5A5A5A5_A5A5A5A5}, // R4
    {4'd4,  2'd0, 4'd14, 1'b1, 8'hA5, 64'hFF00FF00_00FF00FF}, // R4
    {4'd5,  2'd0, 4'd15, 1'b0, 8'h70, 64'h3F800000_3F800000}, // R5
    {4'd5,  2'd0, 4'd15, 1'b0, 8'h80, 64'hC0000000_C0000000}, // R5
    {4'd6,  2'd0, 4'd0,  1'b1, 8'hA5, 64'hFFFFFF5A_FFFFFF5A}, // R6
    {4'd6,  2'd0, 4'd12, 1'b1, 8'hA5, 64'hFFFF5A00_FFFF5A00}, // R6
    {4'd11, 2'd0, 4'd2,  1'b0, 8'h00, 64'h00000000_00000000}, // R11
    {4'd11, 2'd0, 4'd12, 1'b0, 8'h00, 64'h000000FF_000000FF}, // R11
    {4'd7,  2'd1, 4'd1,  1'b0, 8'hA5, 64'h000000A5_000000A5}, // R7
    {4'd7,  2'd2, 4'd3,  1'b1, 8'hA5, 64'hFFFF5AFF_FFFF5AFF}, // R7
    {4'd7,  2'd1, 4'd9,  1'b0, 8'hA5, 64'h00A500A5_00A500A5}, // R7
    {4'd7,  2'd2, 4'd11, 1'b1, 8'hA5, 64'h5AFF5AFF_5AFF5AFF}, // R7
    {4'd11, 2'd1, 4'd5,  1'b0, 8'h00, 64'h00000000_00000000}, // R11
    {4'd7,  2'd2, 4'd7,  1'b1, 8'hFF, 64'h00FFFFFF_00FFFFFF}  // R7
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         few_dregs_i = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [7:0]   imm_i = '0;
  logic [3:0]   cmode_i = '0;
  logic         op_i = 1'b0;
  logic [4:0]   dreg_i = '0;
  logic         quad_i = 1'b0;
  logic [127:0] src_data_i = '0;
  logic         res_valid_o;
  logic         res_we_o;
  logic         res_undef_o;
  logic [127:0] res_data_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  simd_imm_unit u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .few_dregs_i (few_dregs_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .imm_i       (imm_i),
    .cmode_i     (cmode_i),
    .op_i        (op_i),
    .dreg_i      (dreg_i),
    .quad_i      (quad_i),
    .src_data_i  (src_data_i),
    .res_valid_o (res_valid_o),
    .res_we_o    (res_we_o),
    .res_undef_o (res_undef_o),
    .res_data_o  (res_data_o)
  );

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive on falling edge, result sampled one falling edge later
  task automatic issue(input logic [3:0] cm, input logic o, input logic [7:0] im,
                       input logic [4:0] dr, input logic q, input logic [127:0] src);
    req_valid_i = 1'b1; cmode_i = cm; op_i = o; imm_i = im;
    dreg_i = dr; quad_i = q; src_data_i = src;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic check_flags(input string req, input logic v, input logic we, input logic ud);
    check(req, {125'b0, res_valid_o, res_we_o, res_undef_o}, {125'b0, v, we, ud});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL R12 watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] cst, s0, s1, e0, e1;
    repeat (2) @(negedge clk_i);
    // reset state (R12)
    check_flags("R12 reset", 1'b0, 1'b0, 1'b0);
    check("R12 ready", {127'b0, req_ready_o}, 128'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      cst = VEC[i][63:0];
      s0 = SRC[63:0];
      s1 = SRC[127:64];
      unique case (VEC[i][78:77])
        2'd1:    begin e0 = s0 | cst; e1 = s1 | cst; end
        2'd2:    begin e0 = s0 & cst; e1 = s1 & cst; end
        default: begin e0 = cst;      e1 = cst;      end
      endcase
      issue(VEC[i][76:73], VEC[i][72], VEC[i][71:64], 5'd2, 1'b1, SRC);
      check($sformatf("R%0d vec%0d data", VEC[i][82:79], i), res_data_o, {e1, e0});
      check($sformatf("R%0d vec%0d flags", VEC[i][82:79], i),
            {125'b0, res_valid_o, res_we_o, res_undef_o}, {125'b0, 3'b110});
    end

    // R10: 64-bit op, upper half zero
    issue(4'd1, 1'b0, 8'h0F, 5'd3, 1'b0, SRC);
    check("R10 d-reg data", res_data_o, {64'b0, SRC[63:0] | 64'h0000000F_0000000F});
    check_flags("R10 d-reg flags", 1'b1, 1'b1, 1'b0);

    // R8: unallocated encoding
    issue(4'd15, 1'b1, 8'h70, 5'd2, 1'b1, SRC);
    check_flags("R8 undef flags", 1'b1, 1'b0, 1'b1);
    check("R12 undef data zero", res_data_o, 128'b0);

    // R9: quad with odd index
    issue(4'd0, 1'b0, 8'h11, 5'd5, 1'b1, SRC);
    check_flags("R9 quad odd", 1'b1, 1'b0, 1'b1);
    // R9: odd index fine when not quad
    issue(4'd0, 1'b0, 8'h11, 5'd5, 1'b0, SRC);
    check_flags("R9 d odd ok", 1'b1, 1'b1, 1'b0);

    // R9: upper bank with small register file
    few_dregs_i = 1'b1;
    issue(4'd0, 1'b0, 8'h11, 5'd18, 1'b0, SRC);
    check_flags("R9 bank small", 1'b1, 1'b0, 1'b1);
    issue(4'd0, 1'b0, 8'h11, 5'd14, 1'b0, SRC);
    check_flags("R9 low bank small", 1'b1, 1'b1, 1'b0);
    few_dregs_i = 1'b0;
    issue(4'd0, 1'b0, 8'h11, 5'd18, 1'b0, SRC);
    check_flags("R9 bank large", 1'b1, 1'b1, 1'b0);
    check("R9 bank large data", res_data_o, {64'b0, 64'h00000011_00000011});

    // R12: back to back, one result per cycle
    req_valid_i = 1'b1; cmode_i = 4'd0; op_i = 1'b0; imm_i = 8'h01;
    dreg_i = 5'd0; quad_i = 1'b0; src_data_i = SRC;
    @(negedge clk_i);
    check("R12 b2b first", res_data_o, {64'b0, 64'h00000001_00000001});
    imm_i = 8'h02;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R12 b2b second", res_data_o, {64'b0, 64'h00000002_00000002});
    check_flags("R12 b2b flags", 1'b1, 1'b1, 1'b0);
    @(negedge clk_i);
    check_flags("R12 idle", 1'b0, 1'b0, 1'b0);

    // R12: reset clears a pending result
    issue(4'd0, 1'b0, 8'h33, 5'd0, 1'b0, SRC);
    rst_ni = 1'b0;
    #1;
    check_flags("R12 async reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule